// File: doc/BRIEF.md
# 4:2:2 Video Input Demultiplexer

This block sits at the input of a video pipeline. It accepts a single 10-bit multiplexed component stream that runs at twice the pixel rate, one word per clock. The words repeat as Cb, Y, Cr, Y. The block finds the packet phase from either an embedded timing reference sequence or the falling edge of an external horizontal sync. It splits each packet into two pixels and presents them as parallel luma and two chroma channels, with a one-cycle valid strobe per pixel.

Two per-line controls shape the samples. The first removes a luma blanking offset, saturating at zero. The second inverts the top bit of both chroma channels, which converts between offset-binary and two's-complement chroma. The chroma of each odd pixel is not carried in the stream, so the block builds it by rounding the average of the two neighbouring cosited samples. The final pixel of a line repeats the last chroma pair instead.

A separate one-cycle pulse marks the end of each active line.

Top module: `vdmx_top`

## Requirements
- R1: While reset is held, `y_out`, `cb_out`, `cr_out`, `pix_valid` and `line_end` are all zero.
- R2: Within an active line the words arrive as Cb, Y0, Cr, Y1. Pixel 2k carries Y0 with that packet's Cb and Cr, pixel 2k+1 carries Y1, and pixels leave in input order.
- R3: With `sync_sel`=0, a timing reference is 0x3FF, 0x000, 0x000, then a status word. A status word with bit 4 = 0 starts a line, and the next word is a Cb. A 0x3FF word ends the line. No reference word and no word between lines ever appears as a pixel.
- R4: With `sync_sel`=1, the clock on which `hsync_in` is first sampled low carries no data, and the following word is a Cb. The line continues while `hsync_in` stays low, and the word on which it is first sampled high is not used.
- R5: With `luma_off_en`=1, each output luma is the input minus 64, and inputs below 64 give 0. With `luma_off_en`=0, luma passes unchanged.
- R6: With `chroma_inv`=1, bit 9 of both `cb_out` and `cr_out` is inverted. The inversion is applied after interpolation.
- R7: For an odd pixel that is not the last of its line, each chroma output is (C[k] + C[k+1] + 1) >> 1, computed on the raw input codes of the neighbouring cosited samples.
- R8: The odd pixel of a line's final packet repeats that packet's Cb and Cr. A trailing incomplete packet is discarded.
- R9: `line_end` pulses for one cycle. With `sync_sel`=0 it follows the clock that samples a status word with bit 4 = 1. With `sync_sel`=1 it follows the clock that samples `hsync_in` first high.
- R10: For every pixel except the two of a line's final packet, `pix_valid` is asserted by the 6th clock edge after the edge that samples that pixel's luma word.
- R11: `pix_valid` never stays high for three consecutive cycles. Within a line it pulses on every other clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_sel | input | 1 | 0: embedded timing references, 1: external horizontal sync |
| hsync_in | input | 1 | External horizontal sync, active line while low |
| luma_off_en | input | 1 | Subtract the luma blanking offset |
| chroma_inv | input | 1 | Invert the chroma MSBs |
| vid_in | input | DW | Multiplexed input word |
| y_out | output | DW | Pixel luma |
| cb_out | output | DW | Pixel blue-difference chroma |
| cr_out | output | DW | Pixel red-difference chroma |
| pix_valid | output | 1 | One-cycle strobe per output pixel |
| line_end | output | 1 | One-cycle end-of-line pulse |

## Verification
The assertions assume the following about the inputs:
- Active data never holds 0x3FF, so a reference preamble appears only at line edges.
- `hsync_in` stays low for the whole of an externally synced line.
- `luma_off_en` and `chroma_inv` hold steady from the start of a line until its last pixel has left.
- Lines are separated by enough idle words to flush the final packet.

The stimulus keeps data words within 0 to 1020 excluding 0x3FF. It changes the controls only between lines. It follows each line with twelve idle words whose values would be caught as stray pixels if any were emitted.

// File: rtl/vdmx_pkg.sv
package vdmx_pkg;

   typedef enum logic {
      SYNC_EMBED  = 1'b0,
      SYNC_EXTERN = 1'b1
   } sync_mode_e;

   typedef enum logic [1:0] {
      PH_CB = 2'd0,
      PH_Y0 = 2'd1,
      PH_CR = 2'd2,
      PH_Y1 = 2'd3
   } word_phase_e;

endpackage

// File: rtl/vdmx_trs_detect.sv
module vdmx_trs_detect #(
   parameter int DW   = 10,
   parameter int HBIT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] word,
   output logic          sav_hit,
   output logic          eav_hit,
   output logic          ref_start
);
   localparam logic [DW-1:0] ALL_ONES  = '1;
   localparam logic [DW-1:0] ALL_ZEROS = '0;

   logic [DW-1:0] hist1, hist2, hist3;
   logic          preamble;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist1 <= '0;
         hist2 <= '0;
         hist3 <= '0;
      end else begin
         hist3 <= hist2;
         hist2 <= hist1;
         hist1 <= word;
      end
   end

   // the current word is the status word of a reference sequence
   assign preamble  = (hist3 == ALL_ONES) && (hist2 == ALL_ZEROS) && (hist1 == ALL_ZEROS);
   assign sav_hit   = preamble && !word[HBIT];
   assign eav_hit   = preamble &&  word[HBIT];
   assign ref_start = (word == ALL_ONES);

endmodule

// File: rtl/vdmx_capture.sv
module vdmx_capture
   import vdmx_pkg::*;
#(
   parameter int DW       = 10,
   parameter int Y_OFFSET = 64,
   parameter bit SAT_LUMA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_sel,
   input  logic          hsync_in,
   input  logic          luma_off_en,
   input  logic [DW-1:0] word,
   input  logic          sav_hit,
   input  logic          eav_hit,
   input  logic          ref_start,
   output logic          pkt_done,
   output logic [DW-1:0] pkt_cb,
   output logic [DW-1:0] pkt_y0,
   output logic [DW-1:0] pkt_cr,
   output logic [DW-1:0] pkt_y1,
   output logic          line_stop,
   output logic          eol_pulse
);
   localparam logic [DW-1:0] YOFF = DW'(Y_OFFSET);

   word_phase_e   phase;
   logic          active;
   logic          hs_d;
   logic          ext, fall, rise, start, stop, take;
   logic [DW-1:0] cap_cb, cap_y0, cap_cr;
   logic [DW-1:0] y_proc;

   assign ext   = (sync_mode_e'(sync_sel) == SYNC_EXTERN);
   assign fall  = hs_d & ~hsync_in;
   assign rise  = ~hs_d & hsync_in;
   assign start = ext ? fall : sav_hit;
   assign stop  = ext ? rise : ref_start;
   assign take  = active && !stop && !start;

   generate
      if (SAT_LUMA) begin : g_sat
         always_comb begin
            if (!luma_off_en)      y_proc = word;
            else if (word < YOFF)  y_proc = '0;
            else                   y_proc = word - YOFF;
         end

         assert_luma_floor_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            (take && phase == PH_Y0 && luma_off_en && word < YOFF) |=> (cap_y0 == '0));
      end else begin : g_wrap
         always_comb y_proc = luma_off_en ? (word - YOFF) : word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         phase     <= PH_CB;
         hs_d      <= 1'b1;
         cap_cb    <= '0;
         cap_y0    <= '0;
         cap_cr    <= '0;
         eol_pulse <= 1'b0;
      end else begin
         hs_d      <= hsync_in;
         eol_pulse <= ext ? rise : eav_hit;
         if (start) begin
            active <= 1'b1;
            phase  <= PH_CB;
         end else if (stop) begin
            active <= 1'b0;
         end else if (active) begin
            unique case (phase)
               PH_CB: begin cap_cb <= word;   phase <= PH_Y0; end
               PH_Y0: begin cap_y0 <= y_proc; phase <= PH_CR; end
               PH_CR: begin cap_cr <= word;   phase <= PH_Y1; end
               default:                       phase <= PH_CB;
            endcase
         end
      end
   end

   assign pkt_done  = take && (phase == PH_Y1);
   assign pkt_cb    = cap_cb;
   assign pkt_y0    = cap_y0;
   assign pkt_cr    = cap_cr;
   assign pkt_y1    = y_proc;
   assign line_stop = active && stop;

   assert_sav_phase_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ext && sav_hit) |=> (active && phase == PH_CB));

   assert_ref_closes_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ext && ref_start) |=> !active);

   assert_eav_idle_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ext && eav_hit) |-> !active);

   assert_fall_phase_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ext && fall) |=> (active && phase == PH_CB));

endmodule

// File: rtl/vdmx_emit.sv
module vdmx_emit #(
   parameter int DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chroma_inv,
   input  logic          pkt_done,
   input  logic [DW-1:0] pkt_cb,
   input  logic [DW-1:0] pkt_y0,
   input  logic [DW-1:0] pkt_cr,
   input  logic [DW-1:0] pkt_y1,
   input  logic          line_stop,
   output logic [DW-1:0] y_out,
   output logic [DW-1:0] cb_out,
   output logic [DW-1:0] cr_out,
   output logic          pix_valid
);
   localparam logic [DW-1:0] MSB_MASK = {1'b1, {(DW-1){1'b0}}};

   function automatic logic [DW-1:0] avg2(input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [DW:0] s;
      s = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, 1'b1};
      return s[DW:1];
   endfunction

   logic          h_vld;
   logic [DW-1:0] h_cb, h_y0, h_cr, h_y1;
   logic          fl_pend, od_pend, od_wait;
   logic [DW-1:0] od_y, od_cb, od_cr;
   logic [DW-1:0] inv_m;
   logic          take_fl;

   assign inv_m   = chroma_inv ? MSB_MASK : '0;
   assign take_fl = fl_pend && !od_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_vld     <= 1'b0;
         h_cb      <= '0;
         h_y0      <= '0;
         h_cr      <= '0;
         h_y1      <= '0;
         fl_pend   <= 1'b0;
         od_pend   <= 1'b0;
         od_wait   <= 1'b0;
         od_y      <= '0;
         od_cb     <= '0;
         od_cr     <= '0;
         y_out     <= '0;
         cb_out    <= '0;
         cr_out    <= '0;
         pix_valid <= 1'b0;
      end else begin
         pix_valid <= 1'b0;
         if (line_stop && h_vld) fl_pend <= 1'b1;
         if (pkt_done) begin
            h_cb  <= pkt_cb;
            h_y0  <= pkt_y0;
            h_cr  <= pkt_cr;
            h_y1  <= pkt_y1;
            h_vld <= 1'b1;
            if (h_vld) begin
               y_out     <= h_y0;
               cb_out    <= h_cb ^ inv_m;
               cr_out    <= h_cr ^ inv_m;
               pix_valid <= 1'b1;
               od_pend   <= 1'b1;
               od_wait   <= 1'b1;
               od_y      <= h_y1;
               od_cb     <= avg2(h_cb, pkt_cb);
               od_cr     <= avg2(h_cr, pkt_cr);
            end
         end else if (od_pend) begin
            if (od_wait) begin
               od_wait <= 1'b0;
            end else begin
               y_out     <= od_y;
               cb_out    <= od_cb ^ inv_m;
               cr_out    <= od_cr ^ inv_m;
               pix_valid <= 1'b1;
               od_pend   <= 1'b0;
            end
         end else if (take_fl) begin
            y_out     <= h_y0;
            cb_out    <= h_cb ^ inv_m;
            cr_out    <= h_cr ^ inv_m;
            pix_valid <= 1'b1;
            od_pend   <= 1'b1;
            od_wait   <= 1'b1;
            od_y      <= h_y1;
            od_cb     <= h_cb;
            od_cr     <= h_cr;
            h_vld     <= 1'b0;
            fl_pend   <= 1'b0;
         end
      end
   end

   assert_emit_on_packet_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && h_vld) |=> pix_valid);

   assert_pulse_gap_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && $past(pix_valid)) |=> !pix_valid);

   assert_flush_drains_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (fl_pend && !od_pend && !pkt_done) |=> (pix_valid && !h_vld));

endmodule

// File: rtl/vdmx_top.sv
module vdmx_top #(
   parameter int DW       = 10,
   parameter int Y_OFFSET = 64,
   parameter int HBIT     = 4,
   parameter bit SAT_LUMA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_sel,
   input  logic          hsync_in,
   input  logic          luma_off_en,
   input  logic          chroma_inv,
   input  logic [DW-1:0] vid_in,
   output logic [DW-1:0] y_out,
   output logic [DW-1:0] cb_out,
   output logic [DW-1:0] cr_out,
   output logic          pix_valid,
   output logic          line_end
);
   generate
      if (DW < 4) begin : g_bad_width
         $error("vdmx_top: DW must be at least 4");
      end
      if (HBIT >= DW) begin : g_bad_hbit
         $error("vdmx_top: HBIT must index a bit of the word");
      end
      if (Y_OFFSET < 0 || Y_OFFSET >= (1 << DW)) begin : g_bad_offset
         $error("vdmx_top: Y_OFFSET must fit in DW bits");
      end
   endgenerate

   logic          sav_hit, eav_hit, ref_start;
   logic          pkt_done, line_stop;
   logic [DW-1:0] pkt_cb, pkt_y0, pkt_cr, pkt_y1;

   vdmx_trs_detect #(.DW(DW), .HBIT(HBIT)) u_trs (
      .clk       (clk),
      .rst_n     (rst_n),
      .word      (vid_in),
      .sav_hit   (sav_hit),
      .eav_hit   (eav_hit),
      .ref_start (ref_start)
   );

   vdmx_capture #(.DW(DW), .Y_OFFSET(Y_OFFSET), .SAT_LUMA(SAT_LUMA)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_sel    (sync_sel),
      .hsync_in    (hsync_in),
      .luma_off_en (luma_off_en),
      .word        (vid_in),
      .sav_hit     (sav_hit),
      .eav_hit     (eav_hit),
      .ref_start   (ref_start),
      .pkt_done    (pkt_done),
      .pkt_cb      (pkt_cb),
      .pkt_y0      (pkt_y0),
      .pkt_cr      (pkt_cr),
      .pkt_y1      (pkt_y1),
      .line_stop   (line_stop),
      .eol_pulse   (line_end)
   );

   vdmx_emit #(.DW(DW)) u_emit (
      .clk        (clk),
      .rst_n      (rst_n),
      .chroma_inv (chroma_inv),
      .pkt_done   (pkt_done),
      .pkt_cb     (pkt_cb),
      .pkt_y0     (pkt_y0),
      .pkt_cr     (pkt_cr),
      .pkt_y1     (pkt_y1),
      .line_stop  (line_stop),
      .y_out      (y_out),
      .cb_out     (cb_out),
      .cr_out     (cr_out),
      .pix_valid  (pix_valid)
   );

   assert_eol_single_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      line_end |=> !line_end);

endmodule

// File: tb/vdmx_top_bench.sv
module vdmx_top_bench;
   localparam int DW  = 10;
   localparam int LAT = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_sel = 1'b0;
   logic          hsync_in = 1'b1;
   logic          luma_off_en = 1'b0;
   logic          chroma_inv = 1'b0;
   logic [DW-1:0] vid_in = '0;
   logic [DW-1:0] y_out, cb_out, cr_out;
   logic          pix_valid, line_end;

   always #4 clk = ~clk;

   vdmx_top #(.DW(DW)) u_vdmx_top (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_sel    (sync_sel),
      .hsync_in    (hsync_in),
      .luma_off_en (luma_off_en),
      .chroma_inv  (chroma_inv),
      .vid_in      (vid_in),
      .y_out       (y_out),
      .cb_out      (cb_out),
      .cr_out      (cr_out),
      .pix_valid   (pix_valid),
      .line_end    (line_end)
   );

   typedef struct {
      int    y;
      int    cb;
      int    cr;
      int    at;
      bit    lat_ok;
      string ytag;
      string ctag;
   } pix_s;

   int   edges = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   int   last_edge = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;
   bit   v1 = 1'b0;
   bit   v2 = 1'b0;
   pix_s exp_q[$];
   int   eol_q[$];
   pix_s cur;

   always @(posedge clk) edges <= edges + 1;

   function automatic int cw(input int i, input int s);
      return 1 + ((i * 97 + s * 31) % 1020);
   endfunction

   function automatic int yw(input int i, input int s);
      return (i * 53 + s * 11) % 1000;
   endfunction

   function automatic int lum(input int v, input bit off);
      if (!off) return v;
      return (v < 64) ? 0 : v - 64;
   endfunction

   function automatic int chv(input int v, input bit inv);
      return inv ? (v ^ 512) : v;
   endfunction

   function automatic int avg(input int a, input int b);
      return (a + b + 1) / 2;
   endfunction

   task automatic fail_msg(input string req, input string what, input int act, input int exp);
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   // output monitor, sampled between active edges
   always @(negedge clk) begin
      if (mon_en) begin
         if (pix_valid) begin
            n_chk++;
            if (v1 && v2) fail_msg("R11", "valid held three cycles", 3, 2);
            if (exp_q.size() == 0) begin
               n_chk++;
               fail_msg("R3", "stray pixel luma", int'(y_out), -1);
            end else begin
               cur = exp_q.pop_front();
               n_chk++;
               if (int'(y_out) != cur.y) fail_msg(cur.ytag, "luma", int'(y_out), cur.y);
               n_chk++;
               if (int'(cb_out) != cur.cb) fail_msg(cur.ctag, "cb", int'(cb_out), cur.cb);
               n_chk++;
               if (int'(cr_out) != cur.cr) fail_msg(cur.ctag, "cr", int'(cr_out), cur.cr);
               if (cur.lat_ok) begin
                  n_chk++;
                  if (edges != cur.at + LAT) fail_msg("R10", "latency edge", edges, cur.at + LAT);
               end
            end
         end
         if (line_end) begin
            n_chk++;
            if (eol_q.size() == 0) fail_msg("R9", "unexpected line end at edge", edges, -1);
            else if (eol_q[0] != edges) fail_msg("R9", "line end edge", edges, eol_q[0]);
            else void'(eol_q.pop_front());
         end
         v2 = v1;
         v1 = pix_valid;
      end
   end

   task automatic put(input int w, input bit hs);
      @(negedge clk);
      vid_in    = DW'(w);
      hsync_in  = hs;
      last_edge = edges + 1;
   endtask

   task automatic run_line(input bit ext, input bit off, input bit inv, input int npk,
                           input int seed, input bit ramp, input bit partial);
      int   cb[64];
      int   cr[64];
      int   yy[128];
      bit   hs;
      pix_s p;
      for (int k = 0; k < npk; k++) begin
         cb[k]       = cw(4 * k, seed);
         cr[k]       = cw(4 * k + 2, seed);
         yy[2*k]     = ramp ? 2 * k     : yw(2 * k, seed);
         yy[2*k + 1] = ramp ? 2 * k + 1 : yw(2 * k + 1, seed);
      end
      hs = ext ? 1'b0 : 1'b1;
      @(negedge clk);
      sync_sel    = ext;
      luma_off_en = off;
      chroma_inv  = inv;
      hsync_in    = 1'b1;
      vid_in      = DW'(12'h040);
      if (!ext) begin
         // preamble then a status word with bit 4 clear (R3)
         put(1023, 1'b1); put(0, 1'b1); put(0, 1'b1); put('h200, 1'b1);
      end else begin
         // high, then the sampled fall carries no data (R4)
         put('h040, 1'b1); put('h040, 1'b0);
      end
      for (int k = 0; k < npk; k++) begin
         put(cb[k], hs);
         put(yy[2*k], hs);
         p.y      = lum(yy[2*k], off);
         p.cb     = chv(cb[k], inv);
         p.cr     = chv(cr[k], inv);
         p.at     = last_edge;
         p.lat_ok = (k < npk - 1);
         p.ytag   = off ? "R5" : "R2";
         p.ctag   = inv ? "R6" : "R2";
         exp_q.push_back(p);
         put(cr[k], hs);
         put(yy[2*k + 1], hs);
         p.y  = lum(yy[2*k + 1], off);
         p.at = last_edge;
         if (k < npk - 1) begin
            p.cb   = chv(avg(cb[k], cb[k+1]), inv);
            p.cr   = chv(avg(cr[k], cr[k+1]), inv);
            p.ctag = "R7";
         end else begin
            p.cb   = chv(cb[k], inv);
            p.cr   = chv(cr[k], inv);
            p.ctag = "R8";
         end
         exp_q.push_back(p);
      end
      if (partial) begin
         // incomplete packet, must vanish (R8)
         put(cw(999, seed), hs);
         put(yw(999, seed), hs);
      end
      if (!ext) begin
         put(1023, 1'b1); put(0, 1'b1); put(0, 1'b1); put('h274, 1'b1);
      end else begin
         put('h040, 1'b1);
      end
      eol_q.push_back(last_edge);
      for (int i = 0; i < 12; i++) put((i % 2 == 1) ? 'h200 : 'h040, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state under reset
      n_chk++;
      if (y_out != '0 || cb_out != '0 || cr_out != '0 || pix_valid || line_end)
         fail_msg("R1", "outputs under reset", int'(y_out) + int'(cb_out) + int'(cr_out)
                  + int'(pix_valid) + int'(line_end), 0);
      @(negedge clk);
      rst_n  = 1'b1;
      mon_en = 1'b1;

      // sweep both sync modes against both controls
      for (int m = 0; m < 8; m++)
         run_line(m[2], m[1], m[0], 6, m + 1, 1'b0, 1'b0);
      // luma ramp 0..127 across the saturation point (R5)
      run_line(1'b0, 1'b1, 1'b0, 64, 20, 1'b1, 1'b0);
      run_line(1'b1, 1'b0, 1'b0, 64, 21, 1'b1, 1'b0);
      // single-packet line: both pixels come from the flush (R8)
      run_line(1'b1, 1'b0, 1'b1, 1, 30, 1'b0, 1'b0);
      run_line(1'b0, 1'b1, 1'b1, 1, 31, 1'b0, 1'b0);
      // trailing partial packets (R8)
      run_line(1'b0, 1'b0, 1'b0, 3, 40, 1'b0, 1'b1);
      run_line(1'b1, 1'b1, 1'b1, 4, 41, 1'b0, 1'b1);

      repeat (10) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0) fail_msg("R8", "pixels never emitted", exp_q.size(), 0);
      n_chk++;
      if (eol_q.size() != 0) fail_msg("R9", "line ends never seen", eol_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule